// File: doc/BRIEF.md
# Binary Pixel Hit-Time Buffer with Token Drain

This block holds the digital side of an array of binary pixels. While a bunch train is in progress, every pixel whose comparator output is high records the current bunch-crossing number, reduced to eight bits, in one of two local slots. Nothing leaves the array during the train. After the train ends, a token walks the array from the lowest address upward. Each pixel that holds records drives its fixed address and its stored timestamps onto one shared output word, one record per cycle. Empty pixels are passed over without costing a cycle.

A controller opens a train with `train_start`, which wipes every pixel. It closes the train with `train_end`, which launches the drain. Pulsing `train_end` again while idle repeats the drain over the retained records. A single global comparator threshold lies outside this block. The block only sees one binary hit line per pixel.

Top module: `pixel_hit_buffer`

## Requirements
- R1: An accepted `train_start` clears all records and overflow flags in every pixel. A drain of an array with no records emits no word, and `busy` is low again two cycles after the `train_end` pulse.
- R2: While a train is open, a high `hit[i]` at a clock edge stores `bx_num` modulo 256 into pixel i's next free slot.
- R3: Each pixel keeps at most two records. A hit in a further crossing is discarded and sets the pixel's sticky overflow flag, which appears as `rd_ovf` on every word from that pixel.
- R4: Within one crossing, meaning while `bx_num` keeps the same value, a pixel stores at most one record, even if `hit` stays high or pulses again. A changed `bx_num` permits a new record.
- R5: `train_end` during a train starts the drain. `busy` is high in the following cycle. Words appear in consecutive cycles, with no gap for empty pixels, in ascending pixel address, and within a pixel in capture order.
- R6: `rd_last` is high on the final word only. After that word, `rd_valid` and `busy` are low.
- R7: Hits that arrive while idle or while draining are ignored, and `train_start` during a drain is ignored. A later drain shows the records unchanged.
- R8: `rd_addr` of each word equals the index of the pixel that emitted it.
- R9: After reset, `rd_valid`, `rd_last` and `busy` are low.
- R10: `train_end` while idle repeats the drain of the retained records with identical words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | Open a train and clear all pixels (ignored while draining) |
| train_end | input | 1 | Close the train and drain, or repeat the drain when idle |
| bx_num | input | BX_W | Running bunch-crossing number |
| hit | input | NPIX | Per-pixel comparator outputs |
| busy | output | 1 | Drain in progress |
| rd_valid | output | 1 | Output word valid |
| rd_addr | output | 8 | Address of the emitting pixel |
| rd_stamp | output | 8 | Stored crossing number, modulo 256 |
| rd_ovf | output | 1 | Emitting pixel discarded at least one hit |
| rd_last | output | 1 | Final word of the drain |

## Verification
The assertions assume that `train_start` and `train_end` come from one sequencer and behave as pulses. They also assume that `bx_num` stays constant over a crossing, changes between crossings, and is stable around the clock edge. The stimulus drives every input half a cycle away from the sampling edge. It holds `bx_num` across each multi-cycle hit, and it changes the crossing number between table events. It also deliberately drives hits and `train_start` during a drain and hits while idle, because those must leave the stored state alone.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;
    localparam int TS_W   = 8;
    localparam int ADDR_W = 8;
    localparam int SLOTS  = 2;
    localparam int CNT_W  = $clog2(SLOTS + 1);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRAIN = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic [TS_W-1:0]  ts1;
        logic [TS_W-1:0]  ts0;
    } cell_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [TS_W-1:0]   stamp;
        logic              ovf;
        logic              last;
    } word_t;

    function automatic logic [TS_W-1:0] slot_pick(cell_t c, logic sel);
        return sel ? c.ts1 : c.ts0;
    endfunction
endpackage

// File: rtl/pixel_cell.sv
module pixel_cell
    import pixbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            cap_en,
    input  logic            xing_new,
    input  logic            hit,
    input  logic [TS_W-1:0] stamp,
    output cell_t           st
);
    logic taken;
    logic cap_req;

    assign cap_req = cap_en && hit && (xing_new || !taken);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st    <= '0;
            taken <= 1'b0;
        end else begin
            if (xing_new) taken <= 1'b0;
            if (cap_req) begin
                taken <= 1'b1;
                if (st.cnt == CNT_W'(0)) begin
                    st.ts0 <= stamp;
                    st.cnt <= CNT_W'(1);
                end else if (st.cnt == CNT_W'(1)) begin
                    st.ts1 <= stamp;
                    st.cnt <= CNT_W'(2);
                end else begin
                    st.ovf <= 1'b1;
                end
            end
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        st.cnt <= CNT_W'(SLOTS));
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        st.ovf && !clr |=> st.ovf);
    p_ovf_when_full_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(st.ovf) |-> $past(st.cnt) == CNT_W'(SLOTS));
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !cap_en && !clr |=> $stable(st));
endmodule

// File: rtl/token_scan.sv
module token_scan #(
    parameter int NPIX = 16,
    localparam int IW  = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int PW  = $clog2(NPIX + 1)
) (
    input  logic [NPIX-1:0] occ,
    input  logic [PW-1:0]   from,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic            more
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NPIX - 1; i >= 0; i--) begin
            if (occ[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        more = 1'b0;
        for (int i = 0; i < NPIX; i++) begin
            if (found && occ[i] && (i > int'(idx))) more = 1'b1;
        end
    end
endmodule

// File: rtl/pixel_hit_buffer.sv
module pixel_hit_buffer
    import pixbuf_pkg::*;
#(
    parameter int NPIX = 16,
    parameter int BX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              train_start,
    input  logic              train_end,
    input  logic [BX_W-1:0]   bx_num,
    input  logic [NPIX-1:0]   hit,
    output logic              busy,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TS_W-1:0]   rd_stamp,
    output logic              rd_ovf,
    output logic              rd_last
);
    localparam int IW = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int PW = $clog2(NPIX + 1);

    phase_e          phase;
    logic [PW-1:0]   ptr;
    logic            sel;
    logic [BX_W-1:0] bx_prev;
    word_t           word_q;

    logic            start_ok, cap_en, xing_new;
    logic [NPIX-1:0] occ;
    cell_t           cells [NPIX];
    logic            found, more;
    logic [IW-1:0]   idx;
    cell_t           cur;
    logic            pix_done, is_last;

    assign start_ok = train_start && (phase != PH_DRAIN);
    assign cap_en   = (phase == PH_TRAIN);
    assign xing_new = (bx_num != bx_prev);

    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        pixel_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .clr      (start_ok),
            .cap_en   (cap_en),
            .xing_new (xing_new),
            .hit      (hit[g]),
            .stamp    (bx_num[TS_W-1:0]),
            .st       (cells[g])
        );
        assign occ[g] = (cells[g].cnt != '0);
    end

    token_scan #(.NPIX(NPIX)) u_scan (
        .occ   (occ),
        .from  (ptr),
        .found (found),
        .idx   (idx),
        .more  (more)
    );

    assign cur      = cells[idx];
    assign pix_done = (cur.cnt == CNT_W'(1)) || sel;
    assign is_last  = pix_done && !more;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            ptr     <= '0;
            sel     <= 1'b0;
            bx_prev <= '0;
            word_q  <= '0;
        end else begin
            bx_prev <= bx_num;
            word_q  <= '0;
            case (phase)
                PH_IDLE, PH_TRAIN: begin
                    if (start_ok) begin
                        phase <= PH_TRAIN;
                    end else if (train_end) begin
                        phase <= PH_DRAIN;
                        ptr   <= '0;
                        sel   <= 1'b0;
                    end
                end
                PH_DRAIN: begin
                    if (!found) begin
                        phase <= PH_IDLE;
                    end else begin
                        word_q.valid <= 1'b1;
                        word_q.addr  <= ADDR_W'(idx);
                        word_q.stamp <= slot_pick(cur, sel);
                        word_q.ovf   <= cur.ovf;
                        word_q.last  <= is_last;
                        if (pix_done) begin
                            ptr <= PW'(idx) + PW'(1);
                            sel <= 1'b0;
                        end else begin
                            sel <= 1'b1;
                        end
                        if (is_last) phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase == PH_DRAIN);
    assign rd_valid = word_q.valid;
    assign rd_addr  = word_q.addr;
    assign rd_stamp = word_q.stamp;
    assign rd_ovf   = word_q.ovf;
    assign rd_last  = word_q.last;

    p_valid_from_drain_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(phase) == PH_DRAIN);
    p_addr_ascending_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid && $past(rd_valid) |-> rd_addr >= $past(rd_addr));
    p_last_has_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid && !busy);
    p_quiet_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> !rd_valid);
    p_addr_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> int'(rd_addr) < NPIX);
endmodule

// File: tb/sim_pixel_hit_buffer.sv
`timescale 1ns/1ps
module sim_pixel_hit_buffer;
    localparam int NPIX = 16;
    localparam int BX_W = 12;

    typedef struct packed {
        logic [15:0] mask;
        logic [11:0] bx;
        logic [3:0]  hold;
    } ev_t;

    localparam ev_t EVS [6] = '{
        '{16'h0001, 12'd5,   4'd3},
        '{16'h8100, 12'd6,   4'd1},
        '{16'h0001, 12'd261, 4'd1},
        '{16'h0001, 12'd262, 4'd2},
        '{16'h0010, 12'd263, 4'd1},
        '{16'h8000, 12'd270, 4'd4}
    };

    logic clk = 1'b0, rst = 1'b1, train_start = 1'b0, train_end = 1'b0;
    logic [BX_W-1:0] bx_num = '0;
    logic [NPIX-1:0] hit = '0;
    logic busy, rd_valid, rd_ovf, rd_last;
    logic [7:0] rd_addr, rd_stamp;

    int errors = 0, checks = 0;
    int m_cnt [NPIX];
    int m_ts  [NPIX][2];
    bit m_ovf [NPIX];

    always #10 clk = ~clk;

    pixel_hit_buffer #(.NPIX(NPIX), .BX_W(BX_W)) u0 (
        .clk(clk), .rst(rst), .train_start(train_start), .train_end(train_end),
        .bx_num(bx_num), .hit(hit), .busy(busy), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_stamp(rd_stamp), .rd_ovf(rd_ovf), .rd_last(rd_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NPIX; p++) begin
            m_cnt[p] = 0; m_ovf[p] = 0; m_ts[p][0] = 0; m_ts[p][1] = 0;
        end
    endtask

    task automatic model_hit(input logic [15:0] mask, input int bx);
        for (int p = 0; p < NPIX; p++) begin
            if (mask[p]) begin
                if (m_cnt[p] < 2) begin
                    m_ts[p][m_cnt[p]] = bx % 256;
                    m_cnt[p]++;
                end else m_ovf[p] = 1;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); train_start = 1'b1;
        @(negedge clk); train_start = 1'b0;
    endtask

    // drain and compare against the model; disturb drives hits and train_start mid-drain
    task automatic drain(input string tag, input bit disturb);
        int ea [32]; int es [32]; bit eo [32]; int en = 0;
        int n = 0, first = -1, lastc = -1;
        for (int p = 0; p < NPIX; p++)
            for (int s = 0; s < m_cnt[p]; s++) begin
                ea[en] = p; es[en] = m_ts[p][s]; eo[en] = m_ovf[p]; en++;
            end
        @(negedge clk); train_end = 1'b1;
        @(negedge clk); train_end = 1'b0;
        chk(busy == 1'b1, {tag, " R5 busy after train_end"}, busy, 1);
        if (disturb) begin hit = '1; train_start = 1'b1; end
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            train_start = 1'b0;
            if (rd_valid) begin
                if (first < 0) first = c;
                lastc = c;
                if (n < en) begin
                    chk(rd_addr == ea[n], {tag, " R8 addr"}, rd_addr, ea[n]);
                    chk(rd_stamp == es[n], {tag, " R2 stamp"}, rd_stamp, es[n]);
                    chk(rd_ovf == eo[n], {tag, " R3 ovf"}, rd_ovf, eo[n]);
                    chk(rd_last == (n == en - 1), {tag, " R6 last"}, rd_last, n == en - 1);
                end
                n++;
                if (rd_last) break;
            end
        end
        hit = '0;
        chk(n == en, {tag, " R5 word count"}, n, en);
        if (n > 0) chk(lastc - first + 1 == n, {tag, " R5 no gaps"}, lastc - first + 1, n);
        @(negedge clk);
        chk(rd_valid == 1'b0 && busy == 1'b0, {tag, " R6 quiet after drain"}, {rd_valid, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=1 exp=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(!rd_valid && !rd_last && !busy, "R9 reset outputs", {rd_valid, rd_last, busy}, 0);

        // table walk: one train, then drain (R2 R3 R4 R5 R8)
        model_clear();
        pulse_start();
        for (int e = 0; e < 6; e++) begin
            @(negedge clk);
            bx_num = EVS[e].bx;
            hit    = EVS[e].mask;
            for (int h = 1; h < int'(EVS[e].hold); h++) @(negedge clk);
            @(negedge clk);
            hit = '0;
            model_hit(EVS[e].mask, int'(EVS[e].bx));
        end
        drain("table", 1'b0);

        // R7: idle hits ignored; R10: replay drain
        @(negedge clk); bx_num = 12'd400; hit = '1;
        repeat (3) @(negedge clk);
        hit = '0;
        drain("R7 R10 idle replay", 1'b0);

        // R7: hits and train_start during drain ignored
        drain("R7 disturbed", 1'b1);
        drain("R7 after disturb", 1'b0);

        // R4: re-pulsed hit in the same crossing, then a new crossing
        model_clear();
        pulse_start();
        @(negedge clk); bx_num = 12'd1000; hit = 16'h0008;
        @(negedge clk); hit = '0;
        @(negedge clk); hit = 16'h0008;
        @(negedge clk); hit = '0;
        model_hit(16'h0008, 1000);
        @(negedge clk); bx_num = 12'd1001; hit = 16'h0008;
        @(negedge clk); hit = '0;
        model_hit(16'h0008, 1001);
        drain("R4 same crossing", 1'b0);

        // R1: train_start clears; empty drain
        model_clear();
        pulse_start();
        drain("R1 empty", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule